// File: doc/BRIEF.md
# Protection-key rights save/restore unit

This block owns the 32-bit protection-key rights register and moves it in and out of an extended-state save area. A save request carries a component-select mask. When the key component's bit is set, the unit issues one 64-bit write of the zero-extended rights value at a fixed offset of 0xA80 bytes from the save-area base. A restore request carries a requested-feature mask. When the key component's bit is set, the unit reads that word and loads its low 32 bits into the register.

Both operations finish with a one-cycle completion pulse. A restore that changes the register value also raises a one-cycle translation-cache flush request. An unselected operation completes without touching memory. The unit also drives the component in-use vector. Every component reads as in use, except the key component, which reads as not in use while the key-enable input is low.

Top module: `pkey_xstate_unit`

## Requirements
- R1: After reset, `rights` is zero and `mem_valid`, `op_done` and `flush_req` are low.
- R2: A save whose `save_mask` has bit KEY_BIT (default 9) set produces exactly one memory write (`mem_we`=1) at `area_base` + 0xA80, with `mem_wdata` equal to `rights` zero-extended to 64 bits.
- R3: A save whose `save_mask` bit KEY_BIT is clear makes no memory request. `op_done` pulses in the cycle after the request.
- R4: A restore whose `rfbm` has bit KEY_BIT set produces exactly one memory read (`mem_we`=0) at `area_base` + 0xA80. When it completes, `rights` holds `mem_rdata[31:0]`. The upper 32 bits of `mem_rdata` are ignored.
- R5: A restore whose `rfbm` bit KEY_BIT is clear makes no memory request, leaves `rights` unchanged, and pulses `op_done` in the cycle after the request.
- R6: `flush_req` is a one-cycle pulse raised only by a restore whose loaded value differs from the previous `rights`. It is high in the cycle that `rights` first shows the new value, which is the same cycle as `op_done`.
- R7: `inuse` is all ones when `key_enable` is high. When `key_enable` is low, `inuse` is all ones except bit KEY_BIT, which is zero.
- R8: A memory request holds `mem_valid`, `mem_addr`, `mem_we` and `mem_wdata` steady until the cycle in which `mem_done` is high. The operation's single `op_done` pulse follows in the next cycle.
- R9: Requests are ignored while a memory request is outstanding. When `save_req` and `restore_req` arrive together, the save is performed and the restore is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| save_req | input | 1 | Start a save operation (one-cycle pulse) |
| save_mask | input | MASK_W | Active component mask for save |
| restore_req | input | 1 | Start a restore operation (one-cycle pulse) |
| rfbm | input | MASK_W | Requested-feature mask for restore |
| area_base | input | ADDR_W | Save-area base byte address |
| key_enable | input | 1 | Protection-key enable flag |
| inuse | output | MASK_W | Component in-use vector |
| rights | output | RIGHTS_W | Current rights register value |
| op_done | output | 1 | Operation completion pulse |
| flush_req | output | 1 | Translation-cache flush pulse |
| mem_valid | output | 1 | Memory request valid |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | ADDR_W | Memory request byte address |
| mem_wdata | output | 64 | Memory write data |
| mem_rdata | input | 64 | Memory read data, valid with mem_done |
| mem_done | input | 1 | Memory request completed |

## Verification
A corrupted rights register shows up in two places. The next selected save writes the wrong `mem_wdata`. The next restore decides `flush_req` against the wrong previous value. Each of these is visible one handshake later.

A stuck or mis-sequenced request flag shows up as a missing or duplicated write or read, or as an `op_done` that never arrives or arrives twice. The bench sees either one within a few cycles of the memory handshake. Any fault in the in-use logic is visible combinationally on `inuse` in the same cycle that `key_enable` changes.

// File: rtl/pkey_xstate_unit.sv
module pkey_xstate_unit #(
  parameter int ADDR_W   = 48,
  parameter int MASK_W   = 64,
  parameter int KEY_BIT  = 9,
  parameter int RIGHTS_W = 32,
  parameter int SLOT_OFS = 'hA80
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                save_req,
  input  logic [MASK_W-1:0]   save_mask,
  input  logic                restore_req,
  input  logic [MASK_W-1:0]   rfbm,
  input  logic [ADDR_W-1:0]   area_base,
  input  logic                key_enable,
  output logic [MASK_W-1:0]   inuse,
  output logic [RIGHTS_W-1:0] rights,
  output logic                op_done,
  output logic                flush_req,
  output logic                mem_valid,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [63:0]         mem_wdata,
  input  logic [63:0]         mem_rdata,
  input  logic                mem_done
);
  localparam logic [ADDR_W-1:0] SLOT   = ADDR_W'(SLOT_OFS);
  localparam logic [MASK_W-1:0] KEYSEL = MASK_W'(1) << KEY_BIT;

  logic [RIGHTS_W-1:0] loaded;
  assign loaded = mem_rdata[RIGHTS_W-1:0];
  assign inuse  = key_enable ? '1 : ~KEYSEL;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rights    <= '0;
      op_done   <= 1'b0;
      flush_req <= 1'b0;
      mem_valid <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      op_done   <= 1'b0;
      flush_req <= 1'b0;
      if (mem_valid) begin
        if (mem_done) begin
          mem_valid <= 1'b0;
          op_done   <= 1'b0 | 1'b1;
          if (!mem_we) begin
            rights    <= loaded;
            flush_req <= loaded != rights;
          end
        end
      end else if (save_req) begin
        if (save_mask[KEY_BIT]) begin
          mem_valid <= 1'b1;
          mem_we    <= 1'b1;
          mem_addr  <= area_base + SLOT;
          mem_wdata <= {{(64-RIGHTS_W){1'b0}}, rights};
        end else begin
          op_done <= 1'b1;
        end
      end else if (restore_req) begin
        if (rfbm[KEY_BIT]) begin
          mem_valid <= 1'b1;
          mem_we    <= 1'b0;
          mem_addr  <= area_base + SLOT;
        end else begin
          op_done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pkey_xstate_chk.sv
module pkey_xstate_chk #(
  parameter int ADDR_W   = 48,
  parameter int MASK_W   = 64,
  parameter int KEY_BIT  = 9,
  parameter int RIGHTS_W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                key_enable,
  input logic [MASK_W-1:0]   inuse,
  input logic [RIGHTS_W-1:0] rights,
  input logic                op_done,
  input logic                flush_req,
  input logic                mem_valid,
  input logic                mem_we,
  input logic [ADDR_W-1:0]   mem_addr,
  input logic [63:0]         mem_wdata,
  input logic                mem_done
);
  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_done |=> mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
  // R8
  done_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_done |=> op_done && !mem_valid);
  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> !op_done);
  // R6
  flush_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |-> op_done && (rights != $past(rights)));
  // R5
  rights_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_valid && mem_done && !mem_we) |=> $stable(rights));
  // R7
  inuse_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inuse[KEY_BIT] == key_enable);
  // R7
  inuse_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(inuse) >= MASK_W - 1);
endmodule

bind pkey_xstate_unit pkey_xstate_chk #(
  .ADDR_W(ADDR_W), .MASK_W(MASK_W), .KEY_BIT(KEY_BIT), .RIGHTS_W(RIGHTS_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .key_enable(key_enable), .inuse(inuse),
  .rights(rights), .op_done(op_done), .flush_req(flush_req),
  .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_done(mem_done)
);

// File: tb/tb_pkey_xstate_unit.sv
module tb_pkey_xstate_unit;
  localparam int AW = 48;
  localparam int MW = 64;
  localparam int KB = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic save_req = 1'b0, restore_req = 1'b0, key_enable = 1'b0;
  logic [MW-1:0] save_mask = '0, rfbm = '0;
  logic [AW-1:0] area_base = '0;
  logic [MW-1:0] inuse;
  logic [31:0] rights;
  logic op_done, flush_req, mem_valid, mem_we;
  logic [AW-1:0] mem_addr;
  logic [63:0] mem_wdata;
  logic [63:0] mem_rdata = '0;
  logic mem_done = 1'b0;

  int nchk = 0, nfail = 0;
  int txn = 0, lat = 0, cur_lat = 0;
  logic [AW-1:0] last_addr;
  logic last_we;
  logic [63:0] last_wdata;
  logic [31:0] exp_rights = '0;

  always #2 clk = ~clk;

  pkey_xstate_unit dut (
    .clk(clk), .rst_n(rst_n), .save_req(save_req), .save_mask(save_mask),
    .restore_req(restore_req), .rfbm(rfbm), .area_base(area_base),
    .key_enable(key_enable), .inuse(inuse), .rights(rights), .op_done(op_done),
    .flush_req(flush_req), .mem_valid(mem_valid), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_done(mem_done)
  );

  always @(posedge clk) begin
    if (mem_valid && !mem_done) begin
      if (lat == 0) mem_done <= 1'b1;
      else lat <= lat - 1;
    end else begin
      mem_done <= 1'b0;
      lat <= cur_lat;
    end
    if (mem_valid && mem_done) begin
      txn <= txn + 1;
      last_addr <= mem_addr;
      last_we <= mem_we;
      last_wdata <= mem_wdata;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [MW-1:0] exp_inuse(input logic ke);
    return ke ? '1 : ~(MW'(1) << KB);
  endfunction

  task automatic run_op(input bit is_save, input bit sel, input logic [AW-1:0] base,
                        input logic [63:0] rdw, input int l);
    int t0, n;
    logic [MW-1:0] m;
    m = {$urandom, $urandom};
    m[KB] = sel;
    t0 = txn;
    @(negedge clk);
    cur_lat = l;
    area_base = base;
    mem_rdata = rdw;
    if (is_save) begin save_req = 1'b1; save_mask = m; end
    else begin restore_req = 1'b1; rfbm = m; end
    @(negedge clk);
    save_req = 1'b0;
    restore_req = 1'b0;
    n = 0;
    while (!op_done && n < 20) begin @(negedge clk); n++; end
    if (is_save) check(op_done == 1'b1, sel ? "R2 done" : "R3 done", 64'(op_done), 64'd1);
    else check(op_done == 1'b1, sel ? "R4 done" : "R5 done", 64'(op_done), 64'd1);
    if (sel) begin
      check(txn == t0 + 1, "R8 one request", 64'(txn - t0), 64'd1);
      check(last_addr == base + AW'('hA80), "R2/R4 address", 64'(last_addr), 64'(base + AW'('hA80)));
      check(last_we == is_save, "R2/R4 direction", 64'(last_we), 64'(is_save));
      if (is_save) begin
        check(last_wdata == {32'd0, exp_rights}, "R2 wdata", last_wdata, {32'd0, exp_rights});
        check(flush_req == 1'b0, "R6 no flush on save", 64'(flush_req), 64'd0);
      end else begin
        check(rights == rdw[31:0], "R4 loaded", 64'(rights), 64'(rdw[31:0]));
        check(flush_req == (rdw[31:0] != exp_rights), "R6 flush",
              64'(flush_req), 64'(rdw[31:0] != exp_rights));
        exp_rights = rdw[31:0];
      end
    end else begin
      check(n == 0, is_save ? "R3 latency" : "R5 latency", 64'(n), 64'd0);
      check(txn == t0, is_save ? "R3 no request" : "R5 no request", 64'(txn - t0), 64'd0);
      check(rights == exp_rights, "R5 rights kept", 64'(rights), 64'(exp_rights));
      check(flush_req == 1'b0, "R6 no flush", 64'(flush_req), 64'd0);
    end
    @(negedge clk);
    check(op_done == 1'b0 && flush_req == 1'b0, "R8 single pulse",
          64'({op_done, flush_req}), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    int t0;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(rights == 32'd0 && !mem_valid && !op_done && !flush_req, "R1 reset",
          64'({rights, mem_valid, op_done, flush_req}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R7 in-use vector both ways
    key_enable = 1'b0; #1;
    check(inuse == exp_inuse(1'b0), "R7 key off", inuse, exp_inuse(1'b0));
    key_enable = 1'b1; #1;
    check(inuse == exp_inuse(1'b1), "R7 key on", inuse, exp_inuse(1'b1));

    // directed corners
    run_op(1'b1, 1'b1, 48'h0, 64'h0, 0);                          // R2 save of zero
    run_op(1'b0, 1'b1, 48'h1000, 64'hFFFF_FFFF_0000_0000, 2);    // R4 upper ignored, same value: no flush
    run_op(1'b0, 1'b1, 48'h2000, 64'h0000_0000_DEAD_BEEF, 1);    // R6 change -> flush
    run_op(1'b0, 1'b1, 48'h2000, 64'h0000_0000_DEAD_BEEF, 3);    // R6 no change
    run_op(1'b1, 1'b0, 48'h3000, 64'h0, 0);                       // R3
    run_op(1'b0, 1'b0, 48'h3000, 64'h1234, 0);                    // R5
    run_op(1'b1, 1'b1, 48'hFFFF_FFFF_F000, 64'h0, 1);            // R2 write back loaded value

    // R9 both requests together: save wins
    t0 = txn;
    @(negedge clk);
    cur_lat = 2;
    save_mask = MW'(1) << KB; rfbm = MW'(1) << KB;
    mem_rdata = 64'h0000_0000_1111_2222;
    save_req = 1'b1; restore_req = 1'b1;
    @(negedge clk);
    save_req = 1'b0; restore_req = 1'b0;
    // R9 restore issued while busy is ignored
    restore_req = 1'b1;
    @(negedge clk);
    restore_req = 1'b0;
    repeat (8) @(negedge clk);
    check(txn == t0 + 1, "R9 one transfer", 64'(txn - t0), 64'd1);
    check(last_we == 1'b1, "R9 save priority", 64'(last_we), 64'd1);
    check(rights == exp_rights, "R9 rights kept", 64'(rights), 64'(exp_rights));

    // random mix
    for (int i = 0; i < 60; i++) begin
      logic [63:0] rd;
      bit s, sel;
      s = $urandom_range(0, 1);
      sel = ($urandom_range(0, 3) != 0);
      rd = {$urandom, $urandom};
      if ($urandom_range(0, 3) == 0) rd[31:0] = exp_rights;
      run_op(s, sel, AW'({$urandom, $urandom}) & ~AW'(7), rd, $urandom_range(0, 3));
      key_enable = $urandom_range(0, 1); #1;
      check(inuse == exp_inuse(key_enable), "R7 random", inuse, exp_inuse(key_enable));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule